// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM

This block is a synthesizable behavioural model of a synchronous static RAM. It holds a small array of words, each made of four byte lanes of nine bits. Every input is sampled on the rising clock edge. Write data is stored on the edge that samples the write. Read data is registered, so it reaches the outputs one clock after the read is sampled.

An access starts on an edge where one of two address strobes is low: the processor strobe or the controller strobe. That edge latches the address and evaluates the three chip enables. After that, the advance input steps a two-bit burst counter through four beats, in linear or interleaved order. The two strobes follow different rules. The processor strobe always forces a read, even if write enables are low. Writes are only possible with the processor strobe high. A sleep request parks the device after a fixed number of clocks. It wakes after the same number of clocks once the request drops, and the stored contents are kept.

In this model, high impedance on the data outputs is shown by `dataOutEn` low, with `dataOut` held at zero.

Top module: `sync_burst_sram`

## Requirements
- R1: A write happens on an edge where the device is selected, `procStrobeN` is high and at least one write enable is low. `globalWrN` low writes all four lanes, whatever the lane strobes are.
- R2: Byte lane i occupies data bits [9i+8:9i]. With `globalWrN` high and `byteWrEnN` low, only the lanes whose `laneWrN[i]` is low are written. With `byteWrEnN` high, the lane strobes have no effect and the cycle is not a write.
- R3: A read happens on a selected edge with no write when `ctrlStrobeN` or `advanceN` is low. Its word is on `dataOut` after the next rising edge.
- R4: `procStrobeN` low makes the cycle a read of the presented address, even if write enables are low. The addressed word is not changed.
- R5: The address is latched only on an edge where a strobe is low and the chip is enabled. Enabled means `chipEn0N` low, `chipEn1` high and `chipEn2N` low. The enables are looked at only on strobe edges, and the result holds until the next strobe edge.
- R6: While deselected the device is powered down. No write and no read takes place, and the outputs stay high impedance, even when the advance input is low.
- R7: An edge with no strobe and `advanceN` low steps the two-bit burst counter, and the access on that edge uses the stepped count. With `interleaveMode` low, the two low address bits are the latched low bits plus the count, modulo 4.
- R8: With `interleaveMode` high, the two low address bits are the latched low bits XOR the count.
- R9: The burst wraps after four beats. A fifth advance goes back to the latched address.
- R10: After a read edge, `dataOutEn` is high exactly while `outEnN` is low.
- R11: After an edge that sampled a write, the outputs are high impedance whatever the level of `outEnN`.
- R12: From the first edge that samples `sleepReq` high, accesses are ignored and the outputs are high impedance. The device is asleep after four consecutive edges with `sleepReq` high.
- R13: Leaving sleep takes four consecutive edges with `sleepReq` low, during which accesses are still ignored. The edge after those four is a normal access, and the stored data is unchanged.
- R14: `rstN` low leaves the device deselected, awake and with its outputs high impedance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| procStrobeN | input | 1 | Processor address strobe, active low, forces a read |
| ctrlStrobeN | input | 1 | Controller address strobe, active low |
| advanceN | input | 1 | Burst advance, active low |
| chipEn0N | input | 1 | Chip enable, active low |
| chipEn1 | input | 1 | Chip enable, active high |
| chipEn2N | input | 1 | Chip enable, active low |
| globalWrN | input | 1 | Write of all lanes, active low |
| byteWrEnN | input | 1 | Enables the lane strobes, active low |
| laneWrN | input | 4 | Per-lane write strobes, active low |
| outEnN | input | 1 | Output enable, active low |
| sleepReq | input | 1 | Sleep request, active high |
| interleaveMode | input | 1 | Burst order: 0 linear, 1 interleaved |
| addrIn | input | ADDR_W | Word address |
| dataIn | input | 4*LANE_W | Write data |
| dataOut | output | 4*LANE_W | Read data, zero when not driven |
| dataOutEn | output | 1 | High when the outputs drive data |

## Verification
Bursts start at a low address of 0 in linear order and at a low address of 1 in interleaved order. From that start the two orders give different beat sequences, so an order mix-up shows up. The fifth beat separates a wrapping counter from a running one. Write patterns set all lanes at once or an alternating lane mask over a known word, which shows the lane-to-bit mapping and that the lane strobes are ignored when their enable is high. The remaining patterns each change one thing from a normal access: the processor strobe with writes asserted, output enable high, one broken enable at a time, and sleep with accesses attempted. Each one shows whether the decoding lets something through that should be blocked.

// File: rtl/sbsram_pkg.sv
package sbsram_pkg;

  localparam int NUM_LANES = 4;

  typedef enum logic [1:0] {
    SLP_AWAKE,
    SLP_ENTER,
    SLP_ASLEEP,
    SLP_LEAVE
  } sleepState_t;

  typedef struct packed {
    logic                 wrEn;
    logic                 rdEn;
    logic [NUM_LANES-1:0] laneMask;
  } memStrobe_t;

endpackage

// File: rtl/sbsram_ctrl.sv
module sbsram_ctrl
  import sbsram_pkg::*;
#(
  parameter int ADDR_W       = 6,
  parameter int SLEEP_CYCLES = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 procStrobeN,
  input  logic                 ctrlStrobeN,
  input  logic                 advanceN,
  input  logic                 chipEn0N,
  input  logic                 chipEn1,
  input  logic                 chipEn2N,
  input  logic                 globalWrN,
  input  logic                 byteWrEnN,
  input  logic [NUM_LANES-1:0] laneWrN,
  input  logic                 sleepReq,
  input  logic                 interleaveMode,
  input  logic [ADDR_W-1:0]    addrIn,
  output memStrobe_t           strobes,
  output logic [ADDR_W-1:0]    accAddr,
  output logic                 awake
);

  localparam int BURST_W = 2;
  localparam int CNT_W   = $clog2(SLEEP_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(SLEEP_CYCLES - 1);

  sleepState_t          sleepState;
  logic [CNT_W-1:0]     sleepCnt;
  logic                 selected;
  logic [ADDR_W-1:0]    baseAddr;
  logic [BURST_W-1:0]   burstCnt;

  logic                 gateOpen;
  logic                 addrStrobe;
  logic                 enablesOk;
  logic                 selNow;
  logic                 anyWrite;
  logic [NUM_LANES-1:0] laneSel;
  logic [BURST_W-1:0]   stepCnt;
  logic [BURST_W-1:0]   useCnt;
  logic [BURST_W-1:0]   lowBits;

  // Access decode
  always_comb begin
    gateOpen   = (sleepState == SLP_AWAKE) && !sleepReq;
    addrStrobe = !procStrobeN || !ctrlStrobeN;
    enablesOk  = !chipEn0N && chipEn1 && !chipEn2N;
    selNow     = addrStrobe ? enablesOk : selected;
    if (!globalWrN)      laneSel = '1;
    else if (!byteWrEnN) laneSel = ~laneWrN;
    else                 laneSel = '0;
    anyWrite   = |laneSel;

    strobes.laneMask = laneSel;
    strobes.wrEn     = gateOpen && selNow && procStrobeN && anyWrite;
    strobes.rdEn     = gateOpen && selNow &&
                       (!procStrobeN || (!anyWrite && (!ctrlStrobeN || !advanceN)));
  end

  // Burst address generation
  always_comb begin
    stepCnt = burstCnt + BURST_W'(1);
    useCnt  = advanceN ? burstCnt : stepCnt;
    lowBits = interleaveMode ? (baseAddr[BURST_W-1:0] ^ useCnt)
                             : (baseAddr[BURST_W-1:0] + useCnt);
    accAddr = addrStrobe ? addrIn : {baseAddr[ADDR_W-1:BURST_W], lowBits};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selected <= 1'b0;
      baseAddr <= '0;
      burstCnt <= '0;
    end else if (gateOpen) begin
      if (addrStrobe) begin
        selected <= enablesOk;
        if (enablesOk) begin
          baseAddr <= addrIn;
          burstCnt <= '0;
        end
      end else if (!advanceN && selected) begin
        burstCnt <= stepCnt;
      end
    end
  end

  // Sleep sequencing
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sleepState <= SLP_AWAKE;
      sleepCnt   <= '0;
    end else begin
      unique case (sleepState)
        SLP_AWAKE: if (sleepReq) begin
          sleepCnt   <= CNT_W'(1);
          sleepState <= (SLEEP_CYCLES <= 1) ? SLP_ASLEEP : SLP_ENTER;
        end
        SLP_ENTER: begin
          if (!sleepReq) begin
            sleepState <= SLP_AWAKE;
            sleepCnt   <= '0;
          end else if (sleepCnt == LAST_CNT) begin
            sleepState <= SLP_ASLEEP;
            sleepCnt   <= '0;
          end else begin
            sleepCnt <= sleepCnt + CNT_W'(1);
          end
        end
        SLP_ASLEEP: if (!sleepReq) begin
          sleepCnt   <= CNT_W'(1);
          sleepState <= (SLEEP_CYCLES <= 1) ? SLP_AWAKE : SLP_LEAVE;
        end
        SLP_LEAVE: begin
          if (sleepReq) begin
            sleepState <= SLP_ASLEEP;
            sleepCnt   <= '0;
          end else if (sleepCnt == LAST_CNT) begin
            sleepState <= SLP_AWAKE;
            sleepCnt   <= '0;
          end else begin
            sleepCnt <= sleepCnt + CNT_W'(1);
          end
        end
        default: sleepState <= SLP_AWAKE;
      endcase
    end
  end

  assign awake = (sleepState == SLP_AWAKE);

endmodule

// File: rtl/sbsram_datapath.sv
module sbsram_datapath
  import sbsram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANE_W = 9
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  memStrobe_t                    strobes,
  input  logic [ADDR_W-1:0]             accAddr,
  input  logic [NUM_LANES*LANE_W-1:0]   dataIn,
  input  logic                          outEnN,
  output logic [NUM_LANES*LANE_W-1:0]   dataOut,
  output logic                          dataOutEn
);

  localparam int WORD_W = NUM_LANES * LANE_W;
  localparam int DEPTH  = 1 << ADDR_W;

  logic [WORD_W-1:0] rdWord;
  logic              rdValid;

  for (genvar g = 0; g < NUM_LANES; g++) begin : gLane
    logic [LANE_W-1:0] laneMem [DEPTH];
    logic [LANE_W-1:0] laneRd;

    always_ff @(posedge clk) begin
      if (strobes.wrEn && strobes.laneMask[g])
        laneMem[accAddr] <= dataIn[g*LANE_W +: LANE_W];
      if (strobes.rdEn)
        laneRd <= laneMem[accAddr];
    end

    assign rdWord[g*LANE_W +: LANE_W] = laneRd;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdValid <= 1'b0;
    else       rdValid <= strobes.rdEn;
  end

  assign dataOutEn = rdValid && !outEnN;
  assign dataOut   = dataOutEn ? rdWord : '0;

endmodule

// File: rtl/sync_burst_sram.sv
module sync_burst_sram
  import sbsram_pkg::*;
#(
  parameter int ADDR_W       = 6,
  parameter int LANE_W       = 9,
  parameter int SLEEP_CYCLES = 4
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        procStrobeN,
  input  logic                        ctrlStrobeN,
  input  logic                        advanceN,
  input  logic                        chipEn0N,
  input  logic                        chipEn1,
  input  logic                        chipEn2N,
  input  logic                        globalWrN,
  input  logic                        byteWrEnN,
  input  logic [3:0]                  laneWrN,
  input  logic                        outEnN,
  input  logic                        sleepReq,
  input  logic                        interleaveMode,
  input  logic [ADDR_W-1:0]           addrIn,
  input  logic [4*LANE_W-1:0]         dataIn,
  output logic [4*LANE_W-1:0]         dataOut,
  output logic                        dataOutEn
);

  memStrobe_t        strobes;
  logic [ADDR_W-1:0] accAddr;
  logic              awake;

  sbsram_ctrl #(
    .ADDR_W       (ADDR_W),
    .SLEEP_CYCLES (SLEEP_CYCLES)
  ) uCtrl (
    .clk            (clk),
    .rstN           (rstN),
    .procStrobeN    (procStrobeN),
    .ctrlStrobeN    (ctrlStrobeN),
    .advanceN       (advanceN),
    .chipEn0N       (chipEn0N),
    .chipEn1        (chipEn1),
    .chipEn2N       (chipEn2N),
    .globalWrN      (globalWrN),
    .byteWrEnN      (byteWrEnN),
    .laneWrN        (laneWrN),
    .sleepReq       (sleepReq),
    .interleaveMode (interleaveMode),
    .addrIn         (addrIn),
    .strobes        (strobes),
    .accAddr        (accAddr),
    .awake          (awake)
  );

  sbsram_datapath #(
    .ADDR_W (ADDR_W),
    .LANE_W (LANE_W)
  ) uData (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .accAddr   (accAddr),
    .dataIn    (dataIn),
    .outEnN    (outEnN),
    .dataOut   (dataOut),
    .dataOutEn (dataOutEn)
  );

endmodule

// File: rtl/sbsram_checker.sv
module sbsram_checker
  import sbsram_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       procStrobeN,
  input logic       outEnN,
  input logic       sleepReq,
  input logic       dataOutEn,
  input logic       awake,
  input memStrobe_t strobes
);

  p_wr_rd_exclusive_r3: assert property (@(posedge clk) disable iff (!rstN)
    !(strobes.wrEn && strobes.rdEn));

  p_proc_strobe_reads_r4: assert property (@(posedge clk) disable iff (!rstN)
    !procStrobeN |-> !strobes.wrEn);

  p_read_latency_r10: assert property (@(posedge clk) disable iff (!rstN)
    strobes.rdEn |=> (dataOutEn || outEnN));

  p_hiz_after_write_r11: assert property (@(posedge clk) disable iff (!rstN)
    strobes.wrEn |=> !dataOutEn);

  p_sleep_blocks_access_r12: assert property (@(posedge clk) disable iff (!rstN)
    (!awake || sleepReq) |-> !(strobes.wrEn || strobes.rdEn));

  p_sleep_quiet_r13: assert property (@(posedge clk) disable iff (!rstN)
    !awake |-> !dataOutEn);

endmodule

bind sync_burst_sram sbsram_checker uChecker (
  .clk         (clk),
  .rstN        (rstN),
  .procStrobeN (procStrobeN),
  .outEnN      (outEnN),
  .sleepReq    (sleepReq),
  .dataOutEn   (dataOutEn),
  .awake       (awake),
  .strobes     (strobes)
);

// File: tb/tb_sync_burst_sram.sv
`timescale 1ns/1ps
module tb_sync_burst_sram;

  localparam int ADDR_W = 6;
  localparam int LANE_W = 9;
  localparam int WORD_W = 4 * LANE_W;

  typedef struct packed {
    logic [3:0]        req;
    logic              procN;
    logic              ctrlN;
    logic              advN;
    logic [1:0]        ceCode;   // 0 enabled, 1/2/3 breaks one enable
    logic              gwN;
    logic              bweN;
    logic [3:0]        lanesN;
    logic              oeN;
    logic              mode;
    logic [ADDR_W-1:0] addr;
    logic [WORD_W-1:0] din;
    logic              expEn;
    logic [WORD_W-1:0] expData;
  } vec_t;

  localparam logic [WORD_W-1:0] W8  = 36'h1_2345_6789;
  localparam logic [WORD_W-1:0] W9  = 36'hA_0000_0001;
  localparam logic [WORD_W-1:0] W10 = 36'hA_0000_0002;
  localparam logic [WORD_W-1:0] W11 = 36'hA_0000_0003;
  localparam logic [WORD_W-1:0] W9B = 36'hA_07FC_01FF; // lanes 0 and 2 set to all ones

  localparam int NV = 26;
  localparam vec_t VECS [NV] = '{
    '{4'd1,  1,0,1,2'd0, 0,1,4'hF,0,0, 6'd8,  W8,  0, 36'h0}, // R1 full write, hi-Z R11
    '{4'd7,  1,1,0,2'd0, 0,1,4'hF,0,0, 6'd0,  W9,  0, 36'h0}, // R7 burst write beat 1
    '{4'd7,  1,1,0,2'd0, 0,1,4'hF,0,0, 6'd0,  W10, 0, 36'h0},
    '{4'd11, 1,1,0,2'd0, 0,1,4'hF,0,0, 6'd0,  W11, 0, 36'h0}, // R11
    '{4'd3,  1,0,1,2'd0, 1,1,4'hF,0,0, 6'd8,  0,   1, W8},    // R3 read
    '{4'd7,  1,1,0,2'd0, 1,1,4'hF,0,0, 6'd0,  0,   1, W9},    // R7 linear
    '{4'd7,  1,1,0,2'd0, 1,1,4'hF,0,0, 6'd0,  0,   1, W10},
    '{4'd7,  1,1,0,2'd0, 1,1,4'hF,0,0, 6'd0,  0,   1, W11},
    '{4'd9,  1,1,0,2'd0, 1,1,4'hF,0,0, 6'd0,  0,   1, W8},    // R9 wrap
    '{4'd8,  1,0,1,2'd0, 1,1,4'hF,0,1, 6'd9,  0,   1, W9},    // R8 interleaved start
    '{4'd8,  1,1,0,2'd0, 1,1,4'hF,0,1, 6'd0,  0,   1, W8},
    '{4'd8,  1,1,0,2'd0, 1,1,4'hF,0,1, 6'd0,  0,   1, W11},
    '{4'd8,  1,1,0,2'd0, 1,1,4'hF,0,1, 6'd0,  0,   1, W10},
    '{4'd2,  1,0,1,2'd0, 1,0,4'b1010,0,0, 6'd9, 36'hF_FFFF_FFFF, 0, 36'h0}, // R2 lane write
    '{4'd2,  1,0,1,2'd0, 1,1,4'hF,0,0, 6'd9,  0,   1, W9B},
    '{4'd2,  1,0,1,2'd0, 1,1,4'h0,0,0, 6'd9,  0,   1, W9B},   // R2 lanes ignored
    '{4'd4,  0,1,1,2'd0, 0,1,4'hF,0,0, 6'd8,  0,   1, W8},    // R4 forced read
    '{4'd4,  1,0,1,2'd0, 1,1,4'hF,0,0, 6'd8,  0,   1, W8},
    '{4'd10, 1,0,1,2'd0, 1,1,4'hF,1,0, 6'd8,  0,   0, 36'h0}, // R10 OE high
    '{4'd5,  1,0,1,2'd1, 0,1,4'hF,0,0, 6'd8,  0,   0, 36'h0}, // R5 deselect
    '{4'd6,  1,1,0,2'd0, 0,1,4'hF,0,0, 6'd0,  0,   0, 36'h0}, // R6 held deselect
    '{4'd6,  1,0,1,2'd0, 1,1,4'hF,0,0, 6'd8,  0,   1, W8},
    '{4'd5,  1,0,1,2'd2, 0,1,4'hF,0,0, 6'd9,  0,   0, 36'h0},
    '{4'd5,  1,0,1,2'd3, 0,1,4'hF,0,0, 6'd9,  0,   0, 36'h0},
    '{4'd5,  1,0,1,2'd0, 1,1,4'hF,0,0, 6'd9,  0,   1, W9B},
    '{4'd3,  1,1,1,2'd0, 1,1,4'hF,0,0, 6'd0,  0,   0, 36'h0}  // R3 idle is no read
  };

  logic clk = 1'b0;
  logic rstN;
  logic procStrobeN, ctrlStrobeN, advanceN;
  logic chipEn0N, chipEn1, chipEn2N;
  logic globalWrN, byteWrEnN;
  logic [3:0] laneWrN;
  logic outEnN, sleepReq, interleaveMode;
  logic [ADDR_W-1:0] addrIn;
  logic [WORD_W-1:0] dataIn;
  logic [WORD_W-1:0] dataOut;
  logic dataOutEn;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  sync_burst_sram #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .SLEEP_CYCLES(4)) dut (
    .clk(clk), .rstN(rstN), .procStrobeN(procStrobeN), .ctrlStrobeN(ctrlStrobeN),
    .advanceN(advanceN), .chipEn0N(chipEn0N), .chipEn1(chipEn1), .chipEn2N(chipEn2N),
    .globalWrN(globalWrN), .byteWrEnN(byteWrEnN), .laneWrN(laneWrN), .outEnN(outEnN),
    .sleepReq(sleepReq), .interleaveMode(interleaveMode), .addrIn(addrIn),
    .dataIn(dataIn), .dataOut(dataOut), .dataOutEn(dataOutEn)
  );

  task automatic drive(input vec_t v);
    procStrobeN    = v.procN;
    ctrlStrobeN    = v.ctrlN;
    advanceN       = v.advN;
    chipEn0N       = (v.ceCode == 2'd1);
    chipEn1        = (v.ceCode != 2'd2);
    chipEn2N       = (v.ceCode == 2'd3);
    globalWrN      = v.gwN;
    byteWrEnN      = v.bweN;
    laneWrN        = v.lanesN;
    outEnN         = v.oeN;
    interleaveMode = v.mode;
    addrIn         = v.addr;
    dataIn         = v.din;
  endtask

  task automatic check(input string tag, input logic expEn, input logic [WORD_W-1:0] expData);
    checks++;
    if (dataOutEn !== expEn || (expEn && dataOut !== expData)) begin
      errors++;
      $display("FAIL %s: en=%0b data=%h, expected en=%0b data=%h",
               tag, dataOutEn, dataOut, expEn, expData);
    end
  endtask

  function automatic vec_t mk(input logic procN, input logic ctrlN, input logic gwN,
                              input logic [ADDR_W-1:0] a, input logic [WORD_W-1:0] d);
    vec_t v;
    v = '{4'd0, procN, ctrlN, 1'b1, 2'd0, gwN, 1'b1, 4'hF, 1'b0, 1'b0, a, d, 1'b0, '0};
    return v;
  endfunction

  initial begin
    rstN = 1'b0;
    sleepReq = 1'b0;
    drive(mk(1, 1, 1, '0, '0));
    repeat (3) @(negedge clk);
    check("R14 reset state", 1'b0, '0);
    rstN = 1'b1;
    @(negedge clk);

    // Table walk: drive at the falling edge, check at the next falling edge
    for (int i = 0; i < NV; i++) begin
      drive(VECS[i]);
      @(negedge clk);
      check($sformatf("R%0d vector %0d", VECS[i].req, i), VECS[i].expEn, VECS[i].expData);
    end

    // R12: sleep entry, a write attempt during entry is ignored
    sleepReq = 1'b1;
    drive(mk(1, 0, 0, 6'd8, 36'h0));
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check("R12 sleep entry quiet", 1'b0, '0);
    end
    // R13: leave sleep, reads during exit ignored
    sleepReq = 1'b0;
    drive(mk(1, 0, 1, 6'd8, 36'h0));
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check("R13 sleep exit quiet", 1'b0, '0);
    end
    @(negedge clk);
    check("R13 first access after wake keeps data", 1'b1, W8);

    // R14: asynchronous reset clears the output drive
    drive(mk(1, 1, 1, '0, '0));
    rstN = 1'b0;
    #1;
    check("R14 reset drops outputs", 1'b0, '0);
    @(negedge clk);
    rstN = 1'b1;
    // R14/R6: after reset the device is deselected, so advance does nothing
    advanceN = 1'b0;
    @(negedge clk);
    check("R14 deselected after reset", 1'b0, '0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule